// File: doc/BRIEF.md
# Pulse-Encoded Level Link with Loss-of-Signal Watchdog

This block carries one logic level across a barrier that passes only short pulses. The transmit half samples a synchronous input. It emits a one-cycle "set" strobe when the input goes high and a one-cycle "clear" strobe when it goes low. The level itself is never sent. If the input stays still for a configurable number of cycles, the transmit half sends refresh strobes that repeat the present level, so a receiver that missed an edge is still corrected.

The receive half keeps a bistable output. A set strobe drives it high, a clear strobe drives it low, and it holds between strobes. A watchdog counts the cycles since the last valid strobe. When the count reaches the timeout, the sender is taken to be dead: the output falls back to a parameterised default level and the link-valid flag drops. The next valid strobe restores normal tracking at once. If set and clear arrive in the same cycle, the pair is discarded and an error strobe is raised.

The two halves meet only at the top-level ports. The transmit strobes leave the block and the receive strobes enter it, so the channel between them lies outside the block. The timeout must be longer than the refresh interval.

Top module: `pulse_iso_link`

## Requirements
- R1: While reset is asserted, and until the reset synchroniser releases it two clock edges after `rst_n` rises, `tx_set`, `tx_clr` and `pulse_err` are 0, `link_ok` is 0 and `dout` equals `DEFAULT_LVL`.
- R2: When the sampled `din` differs from its value at the previous edge, the next cycle carries exactly one strobe: `tx_set`=1 for a rise, `tx_clr`=1 for a fall.
- R3: After `REFRESH_CYC` consecutive edges with no input change, a refresh strobe is emitted (`tx_set` if `din` is 1, `tx_clr` if 0). It repeats every `REFRESH_CYC` cycles while the input stays still, and an input change restarts the interval.
- R4: `tx_set` and `tx_clr` are never 1 in the same cycle.
- R5: A cycle with `rx_set`=1 and `rx_clr`=0 makes the held level 1 from the next cycle on. `rx_clr`=1 with `rx_set`=0 makes it 0. With no strobe the level holds, and while `link_ok` is 1, `dout` shows it.
- R6: If `TIMEOUT_CYC` consecutive edges pass with no valid strobe, `link_ok` goes to 0 in the next cycle, and `dout` is `DEFAULT_LVL` for as long as `link_ok` is 0.
- R7: The first valid strobe after a timeout sets `link_ok` to 1 and `dout` to that strobe's level in the next cycle.
- R8: `rx_set`=1 together with `rx_clr`=1 raises `pulse_err` for exactly the next cycle. It changes neither the held level nor `link_ok`, and it does not restart the watchdog.
- R9: After reset, `link_ok` stays 0 until the first valid strobe is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Level to carry, synchronous to `clk` |
| tx_set | output | 1 | Transmit strobe: input is (or went) high |
| tx_clr | output | 1 | Transmit strobe: input is (or went) low |
| rx_set | input | 1 | Received set strobe from the channel |
| rx_clr | input | 1 | Received clear strobe from the channel |
| dout | output | 1 | Rebuilt level, or `DEFAULT_LVL` while the link is down |
| link_ok | output | 1 | 1 while valid strobes keep arriving within the timeout |
| pulse_err | output | 1 | One-cycle flag for a set/clear collision |

## Verification
On every cycle, the assertions check that the transmit strobes are mutually exclusive and match the input direction or level. They also check that a valid received strobe fixes the level and raises `link_ok`, that a collision leaves the level untouched, and that a watchdog kick cannot be followed by an immediate expiry. The exact refresh period, the cycle on which the timeout lands, the fallback to the default level and the recovery after silence are shown only by the bench's scenarios. These run the link in loopback across a sweep of hold lengths, then cut the channel and inject strobes and collisions by hand.

// File: rtl/pil_pkg.sv
package pil_pkg;

  typedef enum logic [1:0] {
    PULSE_NONE = 2'b00,
    PULSE_SET  = 2'b01,
    PULSE_CLR  = 2'b10,
    PULSE_BAD  = 2'b11
  } pulse_e;

  function automatic pulse_e classify(input logic set_i, input logic clr_i);
    return pulse_e'({clr_i, set_i});
  endfunction

endpackage

// File: rtl/pil_rst_sync.sv
module pil_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/pil_encoder.sv
module pil_encoder #(
  parameter int unsigned REFRESH_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tx_set,
  output logic tx_clr
);
  localparam int unsigned QW = (REFRESH_CYC > 2) ? $clog2(REFRESH_CYC) : 1;
  localparam logic [QW-1:0] QLAST = QW'(REFRESH_CYC - 1);

  logic          din_q;
  logic [QW-1:0] quiet_q, quiet_n;
  logic          set_q, set_n, clr_q, clr_n;
  logic          moved, refresh;

  always_comb begin
    moved   = (din != din_q);
    refresh = !moved && (quiet_q == QLAST);
    set_n   = (moved && din)  || (refresh && din);
    clr_n   = (moved && !din) || (refresh && !din);
    quiet_n = (moved || refresh) ? '0 : quiet_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q   <= 1'b0;
      quiet_q <= '0;
      set_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      din_q   <= din;
      quiet_q <= quiet_n;
      set_q   <= set_n;
      clr_q   <= clr_n;
    end
  end

  assign tx_set = set_q;
  assign tx_clr = clr_q;

  assert_tx_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_set && tx_clr));

  assert_edge_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (din != din_q) |=> (tx_set == $past(din)) && (tx_clr == !$past(din)));

  assert_refresh_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (din == din_q) |=> !(tx_set && !$past(din)) && !(tx_clr && $past(din)));
endmodule

// File: rtl/pil_watchdog.sv
module pil_watchdog #(
  parameter int unsigned LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic expire
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CLAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] CFULL = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    expire = !kick && (cnt_q == CLAST);
    cnt_en = kick || (cnt_q != CFULL);
    cnt_n  = kick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assert_kick_rearms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !expire);
endmodule

// File: rtl/pil_decoder.sv
module pil_decoder
  import pil_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 500,
  parameter logic        DEFAULT_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_set,
  input  logic rx_clr,
  output logic dout,
  output logic link_ok,
  output logic pulse_err
);
  pulse_e kind;
  logic   valid, expire;
  logic   lvl_q, lvl_n, ok_q, ok_n, err_q, err_n;

  always_comb begin
    kind  = classify(rx_set, rx_clr);
    valid = (kind == PULSE_SET) || (kind == PULSE_CLR);
    lvl_n = valid ? (kind == PULSE_SET) : lvl_q;
    ok_n  = valid ? 1'b1 : (expire ? 1'b0 : ok_q);
    err_n = (kind == PULSE_BAD);
  end

  pil_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick   (valid),
    .expire (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= DEFAULT_LVL;
      ok_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      lvl_q <= lvl_n;
      ok_q  <= ok_n;
      err_q <= err_n;
    end
  end

  assign dout      = ok_q ? lvl_q : DEFAULT_LVL;
  assign link_ok   = ok_q;
  assign pulse_err = err_q;

  assert_set_drives_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set && !rx_clr) |=> (dout == 1'b1));

  assert_clr_drives_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr && !rx_set) |=> (dout == 1'b0));

  assert_valid_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set ^ rx_clr) |=> link_ok);

  assert_collision_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set && rx_clr) |=> pulse_err && $stable(dout) && $stable(link_ok));
endmodule

// File: rtl/pulse_iso_link.sv
module pulse_iso_link #(
  parameter int unsigned REFRESH_CYC = 200,
  parameter int unsigned TIMEOUT_CYC = 500,
  parameter logic        DEFAULT_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tx_set,
  output logic tx_clr,
  input  logic rx_set,
  input  logic rx_clr,
  output logic dout,
  output logic link_ok,
  output logic pulse_err
);
  generate
    if (TIMEOUT_CYC <= REFRESH_CYC || REFRESH_CYC < 2) begin : g_bad_cfg
      $error("TIMEOUT_CYC must exceed REFRESH_CYC, which must be at least 2");
    end
  endgenerate

  logic srst_n;

  pil_rst_sync u_rsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  pil_encoder #(.REFRESH_CYC(REFRESH_CYC)) u_enc (
    .clk    (clk),
    .rst_n  (srst_n),
    .din    (din),
    .tx_set (tx_set),
    .tx_clr (tx_clr)
  );

  pil_decoder #(.TIMEOUT_CYC(TIMEOUT_CYC), .DEFAULT_LVL(DEFAULT_LVL)) u_dec (
    .clk       (clk),
    .rst_n     (srst_n),
    .rx_set    (rx_set),
    .rx_clr    (rx_clr),
    .dout      (dout),
    .link_ok   (link_ok),
    .pulse_err (pulse_err)
  );
endmodule

// File: tb/test_pulse_iso_link.sv
module test_pulse_iso_link;
  localparam int unsigned RC = 8;
  localparam int unsigned TC = 20;
  localparam logic        DL = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic blk = 1'b0;
  logic inj_set = 1'b0;
  logic inj_clr = 1'b0;
  logic tx_set, tx_clr, dout, link_ok, pulse_err;
  wire  rx_set = blk ? inj_set : tx_set;
  wire  rx_clr = blk ? inj_clr : tx_clr;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  pulse_iso_link #(.REFRESH_CYC(RC), .TIMEOUT_CYC(TC), .DEFAULT_LVL(DL)) i_pulse_iso_link (
    .clk(clk), .rst_n(rst_n), .din(din), .tx_set(tx_set), .tx_clr(tx_clr),
    .rx_set(rx_set), .rx_clr(rx_clr), .dout(dout), .link_ok(link_ok),
    .pulse_err(pulse_err)
  );

  // reference state
  logic m_prev = 0, m_set = 0, m_clr = 0, m_lvl = DL, m_ok = 0, m_err = 0;
  int   m_q = 0, m_w = 0, m_kind = 0;

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic advance(input logic d, input logic b, input logic is, input logic ic);
    logic rs, rc, moved, refr;
    rs = b ? is : m_set;
    rc = b ? ic : m_clr;
    m_err = rs && rc;
    if (rs ^ rc) begin
      m_lvl = rs; m_ok = 1; m_w = 0;
    end else begin
      if (m_w == TC - 1) m_ok = 0;
      if (m_w < TC) m_w++;
    end
    moved  = (d != m_prev);
    refr   = !moved && (m_q == RC - 1);
    m_set  = (moved && d) || (refr && d);
    m_clr  = (moved && !d) || (refr && !d);
    m_kind = moved ? 2 : (refr ? 3 : 0);
    m_q    = (moved || refr) ? 0 : m_q + 1;
    m_prev = d;
  endtask

  task automatic cyc(input logic d, input logic b, input logic is, input logic ic);
    logic was_ok;
    @(negedge clk);
    din = d; blk = b; inj_set = is; inj_clr = ic;
    @(posedge clk);
    was_ok = m_ok;
    advance(d, b, is, ic);
    #2;
    chk(tx_set, m_set, (m_kind == 3) ? "R3" : "R2", "tx_set");
    chk(tx_clr, m_clr, (m_kind == 3) ? "R3" : "R2", "tx_clr");
    chk(tx_set && tx_clr, 1'b0, "R4", "tx exclusive");
    chk(dout, m_ok ? m_lvl : DL, m_ok ? "R5" : "R6", "dout");
    chk(link_ok, m_ok, (m_ok && !was_ok) ? "R7" : "R6", "link_ok");
    chk(pulse_err, m_err, "R8", "pulse_err");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    misses++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(tx_set, 1'b0, "R1", "tx_set in reset");
    chk(tx_clr, 1'b0, "R1", "tx_clr in reset");
    chk(link_ok, 1'b0, "R1", "link_ok in reset");
    chk(dout, DL, "R1", "dout in reset");
    chk(pulse_err, 1'b0, "R1", "pulse_err in reset");
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    #2;
    chk(link_ok, 1'b0, "R1", "link_ok during sync release");
    // R9: link stays down until first strobe (din low -> refresh clr after RC)
    for (int i = 0; i < RC - 1; i++) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
      chk(link_ok, 1'b0, "R9", "no strobe yet");
    end
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk(link_ok, 1'b1, "R9", "first strobe raises link");

    // R2/R3 sweep: toggle and hold for every length 1..2*RC+3, loopback
    for (int len = 1; len <= 2 * RC + 3; len++) begin
      for (int k = 0; k < len; k++) cyc(~m_prev ^ (k != 0), 1'b0, 1'b0, 1'b0);
    end
    // fast toggling
    for (int i = 0; i < 12; i++) cyc(i[0], 1'b0, 1'b0, 1'b0);

    // R6: silence the channel with level high, then low
    for (int lv = 0; lv < 2; lv++) begin
      cyc(lv[0], 1'b0, 1'b0, 1'b0);
      cyc(lv[0], 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < TC + 4; i++) cyc(lv[0], 1'b1, 1'b0, 1'b0);
      chk(link_ok, 1'b0, "R6", "timeout after silence");
      chk(dout, DL, "R6", "default after timeout");
      // R8: collision during timeout does not restore
      cyc(lv[0], 1'b1, 1'b1, 1'b1);
      chk(link_ok, 1'b0, "R8", "collision not valid");
      // R7: recovery with a clear, then a set
      cyc(lv[0], 1'b1, 1'b0, 1'b1);
      chk(dout, 1'b0, "R7", "recover low");
      cyc(lv[0], 1'b1, 1'b0, 1'b0);
      cyc(lv[0], 1'b1, 1'b1, 1'b0);
      chk(dout, 1'b1, "R7", "set high");
    end

    // R8: collision while healthy leaves level and does not rearm watchdog
    cyc(1'b0, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < TC - 2; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b1);
    chk(dout, 1'b0, "R8", "level held through collision");
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    chk(link_ok, 1'b0, "R8", "collision did not restart watchdog");

    // R5: injected strobes while healthy, holding between them
    for (int i = 0; i < 16; i++) begin
      cyc(1'b0, 1'b1, i[1], ~i[1] & i[0]);
      cyc(1'b0, 1'b1, 1'b0, 1'b0);
    end

    // reconnect and run loopback to confirm refresh keeps link alive
    for (int i = 0; i < 3 * TC; i++) cyc(i >= TC, 1'b0, 1'b0, 1'b0);
    chk(link_ok, 1'b1, "R3", "refresh keeps link up");
    chk(dout, 1'b1, "R5", "tracked level");

    finish_run();
  end
endmodule